// File: doc/BRIEF.md
# Per-Bank Write Issue Scheduler

This block sits at the heads of several per-bank command queues in a DRAM channel. It decides when each bank's head write may contend for the shared memory controller. It then picks one winner among the contending banks and offers that command to the controller through a valid/ready handshake. A full write becomes a candidate only when the bank's write-data queue already holds at least as many 64-bit words as the command's length. After the offer is accepted, the controller pulls the data at its own pace. The scheduler only observes the word counts.

A masked write changes fewer than eight bytes and always has a length of one word. It is handled in one of two ways, chosen by the ECC enable input at the moment the command is selected:

- **ECC disabled:** it goes out as a single byte-masked write.
- **ECC enabled:** it becomes a read-modify-write. The scheduler first issues a read of the word. When the read data returns, it merges the stored bytes into that data. It then issues a full write of the merged word.

From the read until the write-back, the bank is locked: nothing else from that bank's queue may start. The other banks keep issuing.

Each bank runs a three-state machine:

- `BK_FREE`: no read-modify-write in progress.
- `BK_READ_WAIT`: the read has been accepted and its data is awaited.
- `BK_MERGED`: the merged word is held and ready for write-back.

Its transitions are:

- `BK_FREE`→`BK_READ_WAIT` when a read-modify-write read is accepted.
- `BK_READ_WAIT`→`BK_MERGED` when read data returns for that bank.
- `BK_MERGED`→`BK_FREE` when the write-back is accepted.

The issue port runs a two-state machine:

- `IS_IDLE`: arbitrate and capture a winner.
- `IS_OFFER`: hold the offer until `iss_ready`.

Its transitions are:

- `IS_IDLE`→`IS_OFFER` when any bank requests.
- `IS_OFFER`→`IS_IDLE` on acceptance.

Top module: `wr_issue_sched`

## Requirements
- R1: A bank in `BK_FREE` requests only when its head is valid and its `pd_count` is greater than or equal to `hd_len`. A bank in `BK_READ_WAIT` never requests. A bank in `BK_MERGED` always requests.
- R2: An offer keeps `iss_bank`, `iss_op`, `iss_addr`, `iss_len`, `iss_mask` and `iss_wdata` stable until `iss_ready` is sampled high. On acceptance of op 0, 1 or 3, exactly one `hd_pop` bit (that of `iss_bank`) pulses in the acceptance cycle. Acceptance of op 2 pops nothing.
- R3: `iss_op` encoding is 0 = full write, 1 = byte-masked write, 2 = RMW read, 3 = RMW write-back. An unmasked head issues op 0 with `iss_mask` all ones. A masked head with ECC off issues op 1 with `iss_mask` equal to `hd_bmask`, which has fewer than eight bits set. Bit i of a mask covers data bits 8i+7..8i.
- R4: A masked head with ECC on issues op 2 carrying its byte mask. After the read data returns, the same bank issues op 3 with `iss_mask` all ones and `iss_len` 1. On op 3 acceptance, `pd_take` pulses for that bank.
- R5: The write-back word takes byte i from the bank's `hd_wdata` when mask bit i is 1, and from the returned read data otherwise.
- R6: Between acceptance of a bank's op 2 and acceptance of its op 3, that bank is offered nothing but its op 3. Other banks continue to be offered.
- R7: Selection is round robin. The search starts at a pointer and takes the first requesting bank in ascending order, wrapping around. On each selection the pointer moves to the winner plus one, modulo the bank count.
- R8: A read return (`rd_ret_valid`) to a bank that is not in `BK_READ_WAIT` has no effect.
- R9: After reset no offer is pending, no pop or take pulses, all banks are in `BK_FREE`, and the round-robin pointer is bank 0.
- R10: A winner is captured in a cycle with no offer pending, and its offer appears in the next cycle. After every acceptance there is one cycle without an offer.
- R11: The choice between op 1 and op 2 uses `ecc_en` in the cycle the command is selected. Later changes do not alter the pending offer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | ECC enabled: masked writes become read-modify-write |
| hd_valid | input | NB | Head command present, one bit per bank |
| hd_addr | input | NB*AW | Head address per bank |
| hd_len | input | NB*LW | Head length in 64-bit words per bank |
| hd_masked | input | NB | Head is a masked (partial) write |
| hd_bmask | input | NB*DW/8 | Head byte-enable mask per bank |
| hd_wdata | input | NB*DW | Word at the head of each bank's data queue |
| pd_count | input | NB*CW | Words buffered in each bank's data queue |
| rd_ret_valid | input | 1 | Read data for an RMW read is returning |
| rd_ret_bank | input | BW | Bank of the returning read |
| rd_ret_data | input | DW | Returned read word |
| iss_valid | output | 1 | Offer to the controller is pending |
| iss_ready | input | 1 | Controller accepts the offer |
| iss_op | output | 2 | Operation code of the offer |
| iss_bank | output | BW | Bank of the offer |
| iss_addr | output | AW | Address of the offer |
| iss_len | output | LW | Length of the offer |
| iss_mask | output | DW/8 | Byte mask of the offer |
| iss_wdata | output | DW | Merged word for op 3, zero otherwise |
| hd_pop | output | NB | Pop the bank's command queue head |
| pd_take | output | NB | Consume one word from the bank's data queue (op 3) |

## Verification
The checks assume the following about the inputs:

- A masked head has length one and a mask with at least one set and one clear bit.
- A head stays unchanged until its pop.
- A data count never falls except in response to an accepted write.
- Every length is at least one.

The stimulus builds per-bank command lists that meet these rules and raises each bank's count only in small random steps. It removes exactly the accepted length at each acceptance. It injects read returns both to banks awaiting data and to banks that are not, while toggling the ECC enable and the ready input at random.

// File: rtl/wsched_pkg.sv
`timescale 1ns/1ps
package wsched_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_MASKWR = 2'd1,
        OP_RMW_RD = 2'd2,
        OP_RMW_WR = 2'd3
    } wr_op_e;

    typedef enum logic [1:0] {
        BK_FREE      = 2'd0,
        BK_READ_WAIT = 2'd1,
        BK_MERGED    = 2'd2
    } bank_st_e;

    typedef enum logic {
        IS_IDLE  = 1'b0,
        IS_OFFER = 1'b1
    } iss_st_e;

endpackage

// File: rtl/wsched_byte_merge.sv
`timescale 1ns/1ps
module wsched_byte_merge #(
    parameter int DW = 64,
    localparam int BY = DW / 8
) (
    input  logic [DW-1:0] new_word,
    input  logic [DW-1:0] old_word,
    input  logic [BY-1:0] sel,
    output logic [DW-1:0] merged
);

    for (genvar g = 0; g < BY; g++) begin : g_lane
        assign merged[g*8 +: 8] = sel[g] ? new_word[g*8 +: 8] : old_word[g*8 +: 8];
    end

endmodule

// File: rtl/wsched_bank.sv
`timescale 1ns/1ps
module wsched_bank
    import wsched_pkg::*;
#(
    parameter int DW = 64,
    parameter int LW = 4,
    parameter int CW = 5,
    localparam int BY = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ecc_en,
    input  logic          hd_valid,
    input  logic [LW-1:0] hd_len,
    input  logic          hd_masked,
    input  logic [BY-1:0] hd_bmask,
    input  logic [DW-1:0] hd_wdata,
    input  logic [CW-1:0] pd_count,
    input  logic          ret_hit,
    input  logic [DW-1:0] ret_data,
    input  logic          acc,
    input  wr_op_e        acc_op,
    output logic          req,
    output wr_op_e        req_op,
    output logic [DW-1:0] merged_q
);

    bank_st_e      st_q, st_d;
    logic [DW-1:0] merge_w;
    logic          enough;

    wsched_byte_merge #(.DW(DW)) u_merge (
        .new_word (hd_wdata),
        .old_word (ret_data),
        .sel      (hd_bmask),
        .merged   (merge_w)
    );

    assign enough = (32'(pd_count) >= 32'(hd_len));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BK_FREE;
        end else begin
            st_q <= st_d;
        end
    end

    // merged word holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            merged_q <= '0;
        end else if (st_q == BK_READ_WAIT && ret_hit) begin
            merged_q <= merge_w;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BK_FREE: begin
                if (acc && acc_op == OP_RMW_RD) begin
                    st_d = BK_READ_WAIT;
                end
            end
            BK_READ_WAIT: begin
                if (ret_hit) begin
                    st_d = BK_MERGED;
                end
            end
            BK_MERGED: begin
                if (acc) begin
                    st_d = BK_FREE;
                end
            end
            default: st_d = BK_FREE;
        endcase
    end

    // request outputs
    always_comb begin
        req    = 1'b0;
        req_op = OP_WRITE;
        unique case (st_q)
            BK_FREE: begin
                req = hd_valid && enough;
                if (hd_masked) begin
                    req_op = ecc_en ? OP_RMW_RD : OP_MASKWR;
                end
            end
            BK_READ_WAIT: begin
                req = 1'b0;
            end
            BK_MERGED: begin
                req    = 1'b1;
                req_op = OP_RMW_WR;
            end
            default: req = 1'b0;
        endcase
    end

endmodule

// File: rtl/wsched_rr_arb.sv
`timescale 1ns/1ps
module wsched_rr_arb #(
    parameter int NB = 4,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] req,
    input  logic          adv,
    output logic          any,
    output logic [BW-1:0] win
);

    logic [BW-1:0] ptr_q;
    int            idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= (int'(win) == NB - 1) ? '0 : win + 1'b1;
        end
    end

    // descending scan so the smallest offset from the pointer wins
    always_comb begin
        any = 1'b0;
        win = '0;
        idx = 0;
        for (int k = NB - 1; k >= 0; k--) begin
            idx = int'(ptr_q) + k;
            if (idx >= NB) begin
                idx = idx - NB;
            end
            if (req[idx]) begin
                any = 1'b1;
                win = BW'(idx);
            end
        end
    end

endmodule

// File: rtl/wr_issue_sched.sv
`timescale 1ns/1ps
module wr_issue_sched
    import wsched_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 28,
    parameter int DW = 64,
    parameter int LW = 4,
    parameter int CW = 5,
    localparam int BY = DW / 8,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ecc_en,
    input  logic [NB-1:0]    hd_valid,
    input  logic [NB*AW-1:0] hd_addr,
    input  logic [NB*LW-1:0] hd_len,
    input  logic [NB-1:0]    hd_masked,
    input  logic [NB*BY-1:0] hd_bmask,
    input  logic [NB*DW-1:0] hd_wdata,
    input  logic [NB*CW-1:0] pd_count,
    input  logic             rd_ret_valid,
    input  logic [BW-1:0]    rd_ret_bank,
    input  logic [DW-1:0]    rd_ret_data,
    output logic             iss_valid,
    input  logic             iss_ready,
    output logic [1:0]       iss_op,
    output logic [BW-1:0]    iss_bank,
    output logic [AW-1:0]    iss_addr,
    output logic [LW-1:0]    iss_len,
    output logic [BY-1:0]    iss_mask,
    output logic [DW-1:0]    iss_wdata,
    output logic [NB-1:0]    hd_pop,
    output logic [NB-1:0]    pd_take
);

    iss_st_e       st_q, st_d;
    logic [NB-1:0] breq;
    wr_op_e        bop  [NB];
    logic [DW-1:0] bmrg [NB];
    logic          arb_any;
    logic [BW-1:0] arb_win;
    logic          take_slot;
    logic          hs;

    wr_op_e        lat_op;
    logic [BW-1:0] lat_bank;
    logic [AW-1:0] lat_addr;
    logic [LW-1:0] lat_len;
    logic [BY-1:0] lat_mask;
    logic [DW-1:0] lat_wdata;

    assign hs        = (st_q == IS_OFFER) && iss_ready;
    assign take_slot = (st_q == IS_IDLE) && arb_any;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        wsched_bank #(.DW(DW), .LW(LW), .CW(CW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .ecc_en   (ecc_en),
            .hd_valid (hd_valid[g]),
            .hd_len   (hd_len[g*LW +: LW]),
            .hd_masked(hd_masked[g]),
            .hd_bmask (hd_bmask[g*BY +: BY]),
            .hd_wdata (hd_wdata[g*DW +: DW]),
            .pd_count (pd_count[g*CW +: CW]),
            .ret_hit  (rd_ret_valid && (rd_ret_bank == BW'(g))),
            .ret_data (rd_ret_data),
            .acc      (hs && (lat_bank == BW'(g))),
            .acc_op   (lat_op),
            .req      (breq[g]),
            .req_op   (bop[g]),
            .merged_q (bmrg[g])
        );
    end

    wsched_rr_arb #(.NB(NB)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (breq),
        .adv   (take_slot),
        .any   (arb_any),
        .win   (arb_win)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= IS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IS_IDLE: begin
                if (arb_any) begin
                    st_d = IS_OFFER;
                end
            end
            IS_OFFER: begin
                if (iss_ready) begin
                    st_d = IS_IDLE;
                end
            end
            default: st_d = IS_IDLE;
        endcase
    end

    // capture of the winning command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_op    <= OP_WRITE;
            lat_bank  <= '0;
            lat_addr  <= '0;
            lat_len   <= '0;
            lat_mask  <= '0;
            lat_wdata <= '0;
        end else if (take_slot) begin
            lat_op   <= bop[arb_win];
            lat_bank <= arb_win;
            lat_addr <= hd_addr[arb_win*AW +: AW];
            if (bop[arb_win] == OP_RMW_WR) begin
                lat_len   <= LW'(1);
                lat_wdata <= bmrg[arb_win];
            end else begin
                lat_len   <= hd_len[arb_win*LW +: LW];
                lat_wdata <= '0;
            end
            if (bop[arb_win] == OP_MASKWR || bop[arb_win] == OP_RMW_RD) begin
                lat_mask <= hd_bmask[arb_win*BY +: BY];
            end else begin
                lat_mask <= {BY{1'b1}};
            end
        end
    end

    // outputs
    always_comb begin
        iss_valid = (st_q == IS_OFFER);
        iss_op    = lat_op;
        iss_bank  = lat_bank;
        iss_addr  = lat_addr;
        iss_len   = lat_len;
        iss_mask  = lat_mask;
        iss_wdata = lat_wdata;
        hd_pop    = '0;
        pd_take   = '0;
        for (int b = 0; b < NB; b++) begin
            if (hs && lat_bank == BW'(b)) begin
                hd_pop[b]  = (lat_op != OP_RMW_RD);
                pd_take[b] = (lat_op == OP_RMW_WR);
            end
        end
    end

endmodule

// File: rtl/wsched_chk.sv
`timescale 1ns/1ps
module wsched_chk #(
    parameter int NB = 4,
    parameter int AW = 28,
    parameter int DW = 64,
    parameter int LW = 4,
    parameter int CW = 5,
    localparam int BY = DW / 8,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NB*CW-1:0] pd_count,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [1:0]       iss_op,
    input logic [BW-1:0]    iss_bank,
    input logic [AW-1:0]    iss_addr,
    input logic [LW-1:0]    iss_len,
    input logic [BY-1:0]    iss_mask,
    input logic [DW-1:0]    iss_wdata,
    input logic [NB-1:0]    hd_pop,
    input logic [NB-1:0]    pd_take
);

    logic [NB-1:0] lk;

    // banks observed between an accepted op 2 and its op 3
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk <= '0;
        end else if (iss_valid && iss_ready) begin
            if (iss_op == 2'd2) lk[iss_bank] <= 1'b1;
            if (iss_op == 2'd3) lk[iss_bank] <= 1'b0;
        end
    end

    a_r1_enough_data: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_op != 2'd3) |-> (32'(pd_count[int'(iss_bank)*CW +: CW]) >= 32'(iss_len)));

    a_r2_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_bank) && $stable(iss_op)
            && $stable(iss_addr) && $stable(iss_len) && $stable(iss_mask) && $stable(iss_wdata)));

    a_r2_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hd_pop));

    a_r2_pop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (|hd_pop) |-> (iss_valid && iss_ready && iss_op != 2'd2));

    a_r3_partial_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_op == 2'd1) |-> ($countones(iss_mask) < BY));

    a_r4_take_on_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (|pd_take) |-> (iss_valid && iss_ready && iss_op == 2'd3));

    a_r4_writeback_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_op == 2'd3) |-> lk[iss_bank]);

    a_r6_bank_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && lk[iss_bank]) |-> (iss_op == 2'd3));

    a_r10_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> !iss_valid);

endmodule

bind wr_issue_sched wsched_chk #(
    .NB(NB), .AW(AW), .DW(DW), .LW(LW), .CW(CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_count (pd_count),
    .iss_valid(iss_valid),
    .iss_ready(iss_ready),
    .iss_op   (iss_op),
    .iss_bank (iss_bank),
    .iss_addr (iss_addr),
    .iss_len  (iss_len),
    .iss_mask (iss_mask),
    .iss_wdata(iss_wdata),
    .hd_pop   (hd_pop),
    .pd_take  (pd_take)
);

// File: tb/wr_issue_sched_test.sv
`timescale 1ns/1ps
module wr_issue_sched_test;

    localparam int NB = 4;
    localparam int AW = 28;
    localparam int DW = 64;
    localparam int LW = 4;
    localparam int CW = 5;
    localparam int BY = 8;
    localparam int BW = 2;
    localparam int QD = 24;
    localparam int MAXCYC = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ecc_en = 1'b1;
    logic [NB-1:0]    hd_valid = '0;
    logic [NB*AW-1:0] hd_addr = '0;
    logic [NB*LW-1:0] hd_len = '0;
    logic [NB-1:0]    hd_masked = '0;
    logic [NB*BY-1:0] hd_bmask = '0;
    logic [NB*DW-1:0] hd_wdata = '0;
    logic [NB*CW-1:0] pd_count = '0;
    logic             rd_ret_valid = 1'b0;
    logic [BW-1:0]    rd_ret_bank = '0;
    logic [DW-1:0]    rd_ret_data = '0;
    logic             iss_ready = 1'b0;
    logic             iss_valid;
    logic [1:0]       iss_op;
    logic [BW-1:0]    iss_bank;
    logic [AW-1:0]    iss_addr;
    logic [LW-1:0]    iss_len;
    logic [BY-1:0]    iss_mask;
    logic [DW-1:0]    iss_wdata;
    logic [NB-1:0]    hd_pop;
    logic [NB-1:0]    pd_take;

    always #2.5 clk = ~clk;

    wr_issue_sched uut (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
        .hd_valid(hd_valid), .hd_addr(hd_addr), .hd_len(hd_len),
        .hd_masked(hd_masked), .hd_bmask(hd_bmask), .hd_wdata(hd_wdata),
        .pd_count(pd_count), .rd_ret_valid(rd_ret_valid),
        .rd_ret_bank(rd_ret_bank), .rd_ret_data(rd_ret_data),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
        .iss_bank(iss_bank), .iss_addr(iss_addr), .iss_len(iss_len),
        .iss_mask(iss_mask), .iss_wdata(iss_wdata),
        .hd_pop(hd_pop), .pd_take(pd_take)
    );

    // per-bank command lists and data occupancy
    logic [AW-1:0] q_addr [NB][QD];
    logic [LW-1:0] q_len  [NB][QD];
    logic          q_msk  [NB][QD];
    logic [BY-1:0] q_bm   [NB][QD];
    logic [DW-1:0] q_dat  [NB][QD];
    int            rdp   [NB];
    int            avail [NB];

    // reference model state: 0 free, 1 awaiting read, 2 merged
    int            m_bst [NB];
    logic [DW-1:0] m_mrg [NB];
    int            m_ptr;
    bit            m_offer;
    int            m_bank;
    int            m_op;
    logic [AW-1:0] m_addr;
    logic [LW-1:0] m_len;
    logic [BY-1:0] m_mask;
    logic [DW-1:0] m_wdata;

    int nchk = 0;
    int nfail = 0;

    function automatic logic [DW-1:0] merge_fn(logic [DW-1:0] nw, logic [DW-1:0] od, logic [BY-1:0] sel);
        logic [DW-1:0] r;
        for (int i = 0; i < BY; i++) r[i*8 +: 8] = sel[i] ? nw[i*8 +: 8] : od[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic build_lists();
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < QD; i++) begin
                logic [BY-1:0] m;
                q_addr[b][i] = AW'({$urandom} & 32'h0fff_fff8);
                q_dat[b][i]  = {$urandom, $urandom};
                q_msk[b][i]  = ($urandom % 5) < 2;
                m = BY'($urandom);
                if (m == '1) m[$urandom % BY] = 1'b0;
                if (m == '0) m[0] = 1'b1;
                q_bm[b][i]  = m;
                q_len[b][i] = q_msk[b][i] ? LW'(1) : LW'(1 + ($urandom % 8));
            end
            rdp[b] = 0;
            avail[b] = 0;
            m_bst[b] = 0;
            m_mrg[b] = '0;
        end
        // directed corners: seven-byte mask, single-byte mask, maximum length
        q_msk[0][0] = 1'b1; q_bm[0][0] = 8'h7f; q_len[0][0] = LW'(1);
        q_msk[1][0] = 1'b1; q_bm[1][0] = 8'h01; q_len[1][0] = LW'(1);
        q_msk[2][0] = 1'b1; q_bm[2][0] = 8'hfe; q_len[2][0] = LW'(1);
        q_msk[3][0] = 1'b0; q_len[3][0] = LW'(8);
        m_ptr = 0;
        m_offer = 1'b0;
    endtask

    task automatic drive_inputs();
        for (int b = 0; b < NB; b++) begin
            if (avail[b] < 20 && ($urandom % 2) == 0) avail[b]++;
            pd_count[b*CW +: CW] = CW'(avail[b]);
            if (rdp[b] < QD) begin
                hd_valid[b]             = 1'b1;
                hd_addr[b*AW +: AW]     = q_addr[b][rdp[b]];
                hd_len[b*LW +: LW]      = q_len[b][rdp[b]];
                hd_masked[b]            = q_msk[b][rdp[b]];
                hd_bmask[b*BY +: BY]    = q_bm[b][rdp[b]];
                hd_wdata[b*DW +: DW]    = q_dat[b][rdp[b]];
            end else begin
                hd_valid[b]             = 1'b0;
                hd_addr[b*AW +: AW]     = '0;
                hd_len[b*LW +: LW]      = '0;
                hd_masked[b]            = 1'b0;
                hd_bmask[b*BY +: BY]    = '0;
                hd_wdata[b*DW +: DW]    = '0;
            end
        end
        iss_ready = ($urandom % 10) < 7;
        if (($urandom % 16) == 0) ecc_en = ~ecc_en;   // R11 stimulus
        rd_ret_valid = ($urandom % 3) == 0;            // may target any bank (R8)
        rd_ret_bank  = BW'($urandom);
        rd_ret_data  = {$urandom, $urandom};
    endtask

    task automatic check_outputs();
        logic [NB-1:0] ep, et;
        ep = '0;
        et = '0;
        if (m_offer && iss_ready) begin
            ep[m_bank] = (m_op != 2);
            et[m_bank] = (m_op == 3);
        end
        chk(iss_valid == m_offer, "R1/R10/R7", "iss_valid", 64'(iss_valid), 64'(m_offer));
        if (m_offer && iss_valid) begin
            chk(int'(iss_bank) == m_bank, "R7", "iss_bank", 64'(iss_bank), 64'(m_bank));
            chk(int'(iss_op) == m_op, "R3/R4/R11", "iss_op", 64'(iss_op), 64'(m_op));
            chk(iss_addr == m_addr, "R2", "iss_addr", 64'(iss_addr), 64'(m_addr));
            chk(iss_len == m_len, "R2", "iss_len", 64'(iss_len), 64'(m_len));
            chk(iss_mask == m_mask, "R3", "iss_mask", 64'(iss_mask), 64'(m_mask));
            chk(iss_wdata == m_wdata, "R5/R8", "iss_wdata", iss_wdata, m_wdata);
            chk(!(m_bst[m_bank] == 1), "R6", "offer to locked bank", 64'(m_bst[m_bank]), 64'(0));
        end
        chk(hd_pop == ep, "R2", "hd_pop", 64'(hd_pop), 64'(ep));
        chk(pd_take == et, "R4", "pd_take", 64'(pd_take), 64'(et));
    endtask

    task automatic model_step();
        bit elig [NB];
        int eop  [NB];
        int win;
        for (int b = 0; b < NB; b++) begin
            elig[b] = 1'b0;
            eop[b]  = 0;
            if (m_bst[b] == 0 && rdp[b] < QD && avail[b] >= int'(q_len[b][rdp[b]])) begin
                elig[b] = 1'b1;
                eop[b]  = q_msk[b][rdp[b]] ? (ecc_en ? 2 : 1) : 0;
            end else if (m_bst[b] == 2) begin
                elig[b] = 1'b1;
                eop[b]  = 3;
            end
        end
        win = -1;
        for (int k = 0; k < NB; k++) begin
            int idx;
            idx = (m_ptr + k) % NB;
            if (win < 0 && elig[idx]) win = idx;
        end
        if (rd_ret_valid && m_bst[rd_ret_bank] == 1) begin
            int rb;
            rb = int'(rd_ret_bank);
            m_mrg[rb] = merge_fn(q_dat[rb][rdp[rb]], rd_ret_data, q_bm[rb][rdp[rb]]);
            m_bst[rb] = 2;
        end
        if (m_offer) begin
            if (iss_ready) begin
                case (m_op)
                    0, 1: begin avail[m_bank] -= int'(m_len); rdp[m_bank]++; end
                    2: m_bst[m_bank] = 1;
                    default: begin avail[m_bank] -= 1; rdp[m_bank]++; m_bst[m_bank] = 0; end
                endcase
                m_offer = 1'b0;
            end
        end else if (win >= 0) begin
            m_offer = 1'b1;
            m_bank  = win;
            m_op    = eop[win];
            m_addr  = q_addr[win][rdp[win]];
            m_len   = (eop[win] == 3) ? LW'(1) : q_len[win][rdp[win]];
            m_mask  = (eop[win] == 1 || eop[win] == 2) ? q_bm[win][rdp[win]] : {BY{1'b1}};
            m_wdata = (eop[win] == 3) ? m_mrg[win] : '0;
            m_ptr   = (win + 1) % NB;
        end
    endtask

    function automatic bit drained();
        bit d;
        d = !m_offer;
        for (int b = 0; b < NB; b++) if (rdp[b] < QD || m_bst[b] != 0) d = 1'b0;
        return d;
    endfunction

    initial begin
        bit done;
        void'($urandom(32'd7351));
        build_lists();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R9: nothing offered or pulsed while and right after reset
        chk(iss_valid == 1'b0, "R9", "iss_valid in reset", 64'(iss_valid), 64'(0));
        chk(hd_pop == '0, "R9", "hd_pop in reset", 64'(hd_pop), 64'(0));
        chk(pd_take == '0, "R9", "pd_take in reset", 64'(pd_take), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(iss_valid == 1'b0, "R9", "iss_valid after reset", 64'(iss_valid), 64'(0));
        done = 1'b0;
        for (int cyc = 0; cyc < MAXCYC && !done; cyc++) begin
            @(negedge clk);
            drive_inputs();
            #1;
            check_outputs();
            model_step();
            done = drained();
        end
        // watchdog: every command of every bank must have been issued
        chk(done, "R2", "watchdog drain", 64'(done), 64'(1));
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule